// File: doc/BRIEF.md
# Priority-Chained Interrupt Acknowledge

This block gathers interrupt requests from a set of identical device-side cells onto a single request line toward the processor. The cells are strung into chains. When the processor acknowledges, the grant enters each chain at the cell nearest the processor and travels along it. Cells with nothing pending pass it on. The first cell with a pending request absorbs the grant and places its own vector on a shared vector bus. The processor uses that vector to select a handler.

Several chains form priority groups. A fixed-priority selector admits the acknowledge into only one group: the lowest-numbered group holding a captured request. Pending requests are captured when an acknowledge begins, so a request that arrives while an acknowledge is open cannot change the winner. A take strobe from the processor retires the winner's pending request.

Top module: `intr_chain_top`

## Requirements
- R1: A one-cycle pulse on `dev_req[i]` makes cell i pending from the next clock edge, and `cpu_irq` is high whenever any cell is pending.
- R2: After reset no cell is pending, `cpu_irq` is 0, `vec_valid` is 0 and `vec_bus` is 0.
- R3: Within a group, the pending cell with the lowest position index (nearest the processor) wins the acknowledge, and cells after it see no grant.
- R4: When several groups hold captured requests, the lowest-numbered group wins. Device index i maps to group i / CELLS and position i % CELLS.
- R5: From the cycle after the first clock edge at which `cpu_ack` is sampled high, and for as long as it stays high, `vec_bus` carries VEC_BASE + i for the winning device i (default 0x20 + i) with `vec_valid` 1. While no acknowledge is active, both are 0.
- R6: Pending state is captured at the clock edge that opens an acknowledge. A request whose pulse is sampled at that edge or later does not take part in that acknowledge; it is served by a later one.
- R7: `vec_take` during an active acknowledge clears only the winner's pending request. Other pending requests stay, and `cpu_irq` stays high while any remain.
- R8: An acknowledge that captures no pending request leaves `vec_valid` at 0 and `vec_bus` at 0.
- R9: `vec_take` while no acknowledge is active has no effect on any pending request.
- R10: At most one cell and at most one group hold the grant at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | GROUPS*CELLS | Request pulse per device, group-major order |
| cpu_ack | input | 1 | Processor acknowledge, held high for one acknowledge |
| vec_take | input | 1 | Processor has read the vector; retires the winner |
| cpu_irq | output | 1 | Combined interrupt request |
| vec_valid | output | 1 | A winner is driving the vector bus |
| vec_bus | output | VEC_W | Winner's vector, zero when no cell drives it |

## Verification
The assertions assume that `vec_take` is raised at most once per acknowledge, and never in the same cycle as a request pulse to the winning cell. They also assume that `cpu_ack` stays high for at least two cycles so that a vector can be read. The stimulus opens every acknowledge at a falling edge and holds it for two cycles, with the take in the second cycle. It pulses device requests one cycle at a time, either while no acknowledge is open or exactly at the opening edge when the capture boundary is under test. It also tests an idle take on its own, away from any acknowledge.

// File: rtl/intr_pkg.sv
package intr_pkg;

    typedef struct packed {
        logic pend;
        logic snap;
    } cell_st_t;

    typedef struct packed {
        logic ack_act;
    } top_st_t;

endpackage

// File: rtl/intr_cell.sv
module intr_cell
    import intr_pkg::*;
#(
    parameter int          VEC_W  = 8,
    parameter logic [VEC_W-1:0] VEC_ID = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             snap_i,
    input  logic             hold_i,
    input  logic             take_i,
    input  logic             ack_i,
    output logic             ack_o,
    output logic             win_o,
    output logic             snap_o,
    output logic             pend_o,
    output logic [VEC_W-1:0] vec_o
);

    cell_st_t st_d, st_q;

    always_comb begin
        win_o  = ack_i & st_q.snap;
        ack_o  = ack_i & ~st_q.snap;
        vec_o  = win_o ? VEC_ID : '0;
        snap_o = st_q.snap;
        pend_o = st_q.pend;

        st_d      = st_q;
        st_d.pend = (st_q.pend & ~(win_o & take_i)) | req_i;
        if (snap_i)
            st_d.snap = st_q.pend;
        else if (!hold_i)
            st_d.snap = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_o && take_i && !req_i) |=> !pend_o);

    // R6
    snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !snap_i) |=> $stable(snap_o));

endmodule

// File: rtl/intr_chain.sv
module intr_chain
    import intr_pkg::*;
#(
    parameter int               CELLS    = 4,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CELLS-1:0] req_i,
    input  logic             snap_i,
    input  logic             hold_i,
    input  logic             take_i,
    input  logic             grant_i,
    output logic             any_snap_o,
    output logic             any_pend_o,
    output logic             win_o,
    output logic [VEC_W-1:0] vec_o
);

    logic [CELLS:0]   ack_w;
    logic [CELLS-1:0] win_w, snap_w, pend_w;
    logic [VEC_W-1:0] vec_w [CELLS];

    assign ack_w[0] = grant_i;

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        localparam logic [VEC_W-1:0] ID = VEC_BASE + VEC_W'(c);
        intr_cell #(.VEC_W(VEC_W), .VEC_ID(ID)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (req_i[c]),
            .snap_i (snap_i),
            .hold_i (hold_i),
            .take_i (take_i),
            .ack_i  (ack_w[c]),
            .ack_o  (ack_w[c+1]),
            .win_o  (win_w[c]),
            .snap_o (snap_w[c]),
            .pend_o (pend_w[c]),
            .vec_o  (vec_w[c])
        );
    end

    always_comb begin
        vec_o = '0;
        for (int c = 0; c < CELLS; c++) vec_o = vec_o | vec_w[c];
    end

    assign any_snap_o = |snap_w;
    assign any_pend_o = |pend_w;
    assign win_o      = |win_w;

    // R10
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_w));

    // R3
    tail_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|win_w) |-> !ack_w[CELLS]);

endmodule

// File: rtl/intr_grp_pick.sv
module intr_grp_pick #(
    parameter int GROUPS = 2
) (
    input  logic [GROUPS-1:0] hit_i,
    output logic [GROUPS-1:0] sel_o
);

    always_comb begin
        sel_o = '0;
        for (int g = GROUPS - 1; g >= 0; g--) begin
            if (hit_i[g]) sel_o = GROUPS'(1) << g;
        end
    end

endmodule

// File: rtl/intr_chain_top.sv
module intr_chain_top
    import intr_pkg::*;
#(
    parameter int               GROUPS   = 2,
    parameter int               CELLS    = 4,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [GROUPS*CELLS-1:0] dev_req,
    input  logic                    cpu_ack,
    input  logic                    vec_take,
    output logic                    cpu_irq,
    output logic                    vec_valid,
    output logic [VEC_W-1:0]        vec_bus
);

    top_st_t st_d, st_q;

    logic              snap_w;
    logic [GROUPS-1:0] hit_w, sel_w, pend_w, win_w;
    logic [VEC_W-1:0]  gvec_w [GROUPS];

    always_comb begin
        st_d         = st_q;
        st_d.ack_act = cpu_ack;
        snap_w       = cpu_ack & ~st_q.ack_act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    intr_grp_pick #(.GROUPS(GROUPS)) u_pick (
        .hit_i (hit_w),
        .sel_o (sel_w)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        localparam logic [VEC_W-1:0] GBASE = VEC_BASE + VEC_W'(g * CELLS);
        intr_chain #(.CELLS(CELLS), .VEC_W(VEC_W), .VEC_BASE(GBASE)) u_chain (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (dev_req[g*CELLS +: CELLS]),
            .snap_i     (snap_w),
            .hold_i     (st_q.ack_act),
            .take_i     (vec_take & st_q.ack_act),
            .grant_i    (st_q.ack_act & sel_w[g]),
            .any_snap_o (hit_w[g]),
            .any_pend_o (pend_w[g]),
            .win_o      (win_w[g]),
            .vec_o      (gvec_w[g])
        );
    end

    always_comb begin
        vec_bus = '0;
        for (int g = 0; g < GROUPS; g++) vec_bus = vec_bus | gvec_w[g];
    end

    assign vec_valid = |win_w;
    assign cpu_irq   = |pend_w;

    // R10
    one_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_w));

    // R5
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ack_act |-> (vec_bus == '0 && !vec_valid));

    // R1
    req_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_req) |=> cpu_irq);

    // R9
    idle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && vec_take && !st_q.ack_act) |=> cpu_irq);

endmodule

// File: tb/tb_intr_chain_top.sv
module tb_intr_chain_top;

    localparam int G = 2;
    localparam int C = 4;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [G*C-1:0] dev_req;
    logic         cpu_ack, vec_take;
    logic         cpu_irq, vec_valid;
    logic [W-1:0] vec_bus;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic         valid;
        logic [W-1:0] vec;
        string        tag;
    } exp_t;

    exp_t  exp_q[$];
    event  mon_ev;

    always #10 clk = ~clk;

    intr_chain_top #(.GROUPS(G), .CELLS(C), .VEC_W(W), .VEC_BASE(8'h20)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_req   (dev_req),
        .cpu_ack   (cpu_ack),
        .vec_take  (vec_take),
        .cpu_irq   (cpu_irq),
        .vec_valid (vec_valid),
        .vec_bus   (vec_bus)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected item and compares it with the bus
    always @(mon_ev) begin
        exp_t e;
        if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: actual empty-queue expected item");
        end else begin
            e = exp_q.pop_front();
            check({e.tag, " valid"}, W'(vec_valid), W'(e.valid));
            check({e.tag, " vector"}, vec_bus, e.vec);
        end
    end

    task automatic pulse_req(input int idx);
        @(negedge clk);
        dev_req[idx] = 1'b1;
        @(negedge clk);
        dev_req = '0;
    endtask

    // driver: opens one acknowledge, queues the expected result, optionally takes
    task automatic do_ack(input bit take, input logic ev, input logic [W-1:0] evec,
                          input string tag, input int mid_req);
        exp_t e;
        @(negedge clk);
        cpu_ack = 1'b1;
        if (mid_req >= 0) dev_req[mid_req] = 1'b1;
        @(negedge clk);
        dev_req = '0;
        e.valid = ev; e.vec = evec; e.tag = tag;
        exp_q.push_back(e);
        -> mon_ev;
        #1;
        vec_take = take;
        @(negedge clk);
        vec_take = 1'b0;
        cpu_ack  = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #3_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; dev_req = '0; cpu_ack = 1'b0; vec_take = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check("R2 irq", W'(cpu_irq), 8'h0);
        check("R2 valid", W'(vec_valid), 8'h0);
        check("R2 bus", vec_bus, 8'h0);

        // R8 empty acknowledge
        do_ack(1'b1, 1'b0, 8'h00, "R8 empty ack", -1);

        // R1 single request in group 1
        pulse_req(5);
        check("R1 irq raised", W'(cpu_irq), 8'h1);
        do_ack(1'b1, 1'b1, 8'h25, "R5 single dev5", -1);
        check("R7 irq cleared", W'(cpu_irq), 8'h0);

        // R3 position priority inside group 0
        pulse_req(2);
        pulse_req(1);
        do_ack(1'b1, 1'b1, 8'h21, "R3 nearest wins", -1);
        check("R7 other kept", W'(cpu_irq), 8'h1);
        do_ack(1'b1, 1'b1, 8'h22, "R7 remaining dev2", -1);
        check("R7 all cleared", W'(cpu_irq), 8'h0);

        // R4 group priority
        pulse_req(6);
        pulse_req(3);
        do_ack(1'b1, 1'b1, 8'h23, "R4 group0 first", -1);
        do_ack(1'b1, 1'b1, 8'h26, "R4 group1 next", -1);
        check("R4 irq low", W'(cpu_irq), 8'h0);

        // R6 request at the opening edge does not join
        pulse_req(7);
        do_ack(1'b1, 1'b1, 8'h27, "R6 late req excluded", 0);
        check("R6 late req pending", W'(cpu_irq), 8'h1);
        do_ack(1'b1, 1'b1, 8'h20, "R6 late req served", -1);

        // R9 idle take ignored
        pulse_req(4);
        @(negedge clk);
        vec_take = 1'b1;
        @(negedge clk);
        vec_take = 1'b0;
        @(negedge clk);
        check("R9 idle take", W'(cpu_irq), 8'h1);
        do_ack(1'b1, 1'b1, 8'h24, "R9 still served", -1);

        // R8 acknowledge without take leaves nothing when empty
        do_ack(1'b0, 1'b0, 8'h00, "R8 empty again", -1);
        check("R2 final irq", W'(cpu_irq), 8'h0);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule